// File: doc/BRIEF.md
# Command Ring Sequencer for Interrupt Translation

This block walks a ring of fixed-size command records that software places in memory. Software sets the ring base address and the ring depth in records, then publishes work by writing a producer index into a write-pointer register. While the unit is enabled, the block fetches the first 64-bit little-endian doubleword of the record at the consumer index over a single-outstanding memory read port. It decodes the opcode from the low byte. The two mapping opcodes are handed to an external executor through a start/done/error handshake. Every other opcode is retired at once with no side effect.

After each record completes, the consumer index advances and wraps at the ring depth. A failed memory read, or a failed executor transaction, freezes the ring on the failing record and raises a sticky stall flag. New writes do not restart a stalled ring. Disabling the unit clears the stall, and enabling it again resumes from the frozen record. Semantic faults inside a mapping command are the executor's concern: the executor reports done without error, and the ring moves on.

Top module: `cmdq_engine`

## Requirements
- R1: The fetch for record index i reads address cfg_base + 32*i. Only one read is outstanding at a time. mem_req and mem_addr stay steady until mem_rvalid.
- R2: The write-pointer readback holds the index in bits [19:5] with bit 0 always 0, even when bit 0 was written as 1. The read-pointer readback holds the consumer index in bits [19:5] and the stall flag in bit 0. Both read 0 after reset.
- R3: No record is fetched while unit_en is low. Pending work starts when unit_en is raised.
- R4: A written index not less than cfg_depth is rejected: no record is fetched, and the consumer index is unchanged.
- R5: Records are processed in order until the consumer index equals the producer index. The consumer index wraps from cfg_depth-1 to 0.
- R6: Opcodes 0x08 and 0x09 (low byte of the first doubleword) raise exe_start with that opcode and the record address. All other values retire without exe_start; these include 0x03, 0x04, 0x05, 0x0A, 0x0B, 0x0F and undefined codes.
- R7: A read answered with mem_rerr sets the stall flag and leaves the consumer index on the failing record.
- R8: An executor completion with exe_err sets the stall flag and leaves the consumer index on that record.
- R9: While stalled, writes to the write pointer start no fetch. Lowering unit_en clears the stall without moving the consumer index.
- R10: exe_start is a one-cycle pulse, raised only while no read is outstanding. The next record is not fetched before exe_done.
- R11: busy is high from the cycle after a write that creates runnable work until the last record retires or the ring stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Translation unit enable |
| cfg_base | input | AW | Ring base byte address (32-byte aligned) |
| cfg_depth | input | IDX_W+1 | Ring depth in records |
| wp_we | input | 1 | Write strobe for the write-pointer register |
| wp_wdata | input | 32 | Write-pointer register write data |
| wp_rdata | output | 32 | Write-pointer register readback |
| rp_rdata | output | 32 | Read-pointer and stall readback |
| busy | output | 1 | Records remain to be processed |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read data, first doubleword of the record |
| mem_rerr | input | 1 | Read response error |
| exe_start | output | 1 | One-cycle start for a mapping command |
| exe_opcode | output | 8 | Opcode of the mapping command |
| exe_addr | output | AW | Byte address of the mapping record |
| exe_done | input | 1 | Executor completion |
| exe_err | input | 1 | Executor transaction error, valid with exe_done |

## Verification
The ring is swept over every depth from 1 to 6. Producer indices are chosen so that runs come in zero, short, full-minus-one and wrapping lengths. Each run is compared against an arithmetic walk of the ring that tells a correct wrap from one that overshoots or stops early. The opcode of each record depends on its index and cycles through all eight defined codes plus two undefined ones. This separates the two mapping codes from their neighbours and from codes that differ only in upper data bits. Rejected indices, disabled starts, read errors and executor errors are placed mid-run and across the wrap. These runs show that the index freezes on the right record, that the stall survives writes, and that resumption after a disable picks up exactly where the ring stopped.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  // Opcodes forwarded to the mapping executor; every other code retires
  // directly (raise 0x03, wipe 0x04, barrier 0x05, map-translation 0x0A,
  // map-identity 0x0B, drop 0x0F, and anything undefined).
  localparam logic [7:0] OP_MAP_DEV  = 8'h08;
  localparam logic [7:0] OP_MAP_COLL = 8'h09;

  localparam int unsigned REC_SHIFT = 5;   // 32-byte records
  localparam int unsigned REG_W     = 32;  // pointer register width

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_KICK,
    ST_EXEC
  } seq_state_e;

  function automatic logic needs_exec(input logic [7:0] op);
    return (op == OP_MAP_DEV) || (op == OP_MAP_COLL);
  endfunction

endpackage

// File: rtl/cmdq_rst_sync.sv
module cmdq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/cmdq_ptr_regs.sv
module cmdq_ptr_regs
  import cmdq_pkg::*;
#(
  parameter int unsigned IDX_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_we,
  input  logic [REG_W-1:0]   wp_wdata,
  input  logic [IDX_W:0]     cfg_depth,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               stall,
  output logic [IDX_W-1:0]   wr_idx,
  output logic               wr_ok,
  output logic [REG_W-1:0]   wp_rdata,
  output logic [REG_W-1:0]   rp_rdata
);

  localparam int unsigned IDX_LO = REC_SHIFT;
  localparam int unsigned IDX_HI = REC_SHIFT + IDX_W - 1;
  localparam int unsigned PAD_W  = REG_W - IDX_W - REC_SHIFT;

  logic [IDX_W-1:0] wr_idx_q;
  logic [IDX_W-1:0] wr_idx_d;
  logic             wr_idx_en;

  // Bits outside the index field (including the retry bit) are not stored.
  logic unused_wdata;
  assign unused_wdata = ^{wp_wdata[REG_W-1:IDX_HI+1], wp_wdata[IDX_LO-1:0]};

  always_comb begin
    wr_idx_en = wp_we;
    wr_idx_d  = wp_wdata[IDX_HI:IDX_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
    end else if (wr_idx_en) begin
      wr_idx_q <= wr_idx_d;
    end
  end

  assign wr_idx   = wr_idx_q;
  assign wr_ok    = {1'b0, wr_idx_q} < cfg_depth;
  assign wp_rdata = {{PAD_W{1'b0}}, wr_idx_q, {REC_SHIFT{1'b0}}};
  assign rp_rdata = {{PAD_W{1'b0}}, rd_idx, {(REC_SHIFT-1){1'b0}}, stall};

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int unsigned IDX_W = 15,
  parameter int unsigned AW    = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unit_en,
  input  logic [AW-1:0]      cfg_base,
  input  logic [IDX_W:0]     cfg_depth,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_ok,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               stall,
  output logic               busy,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_rvalid,
  input  logic [63:0]        mem_rdata,
  input  logic               mem_rerr,
  output logic               exe_start,
  output logic [7:0]         exe_opcode,
  input  logic               exe_done,
  input  logic               exe_err
);

  localparam int unsigned OFS_PAD = AW - IDX_W - REC_SHIFT;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] rd_q;
  logic [IDX_W-1:0] rd_wrap;
  logic             stall_q;
  logic [7:0]       op_q;

  logic             pending;
  logic             retire;
  logic             stall_set;
  logic             stall_clr;
  logic             op_ld;
  logic [7:0]       fetched_op;
  logic [IDX_W:0]   rd_plus;

  // Only the opcode byte of the first doubleword is consumed here.
  logic unused_rdata;
  assign unused_rdata = ^mem_rdata[63:8];

  assign fetched_op = mem_rdata[7:0];
  assign pending    = unit_en & ~stall_q & wr_ok & (rd_q != wr_idx);
  assign rd_plus    = {1'b0, rd_q} + {{IDX_W{1'b0}}, 1'b1};
  assign rd_wrap    = (rd_plus >= cfg_depth) ? '0 : rd_plus[IDX_W-1:0];

  // Next-state and enable decode
  always_comb begin
    state_d   = state_q;
    retire    = 1'b0;
    stall_set = 1'b0;
    op_ld     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pending) begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_rvalid) begin
          if (mem_rerr) begin
            stall_set = 1'b1;
            state_d   = ST_IDLE;
          end else if (needs_exec(fetched_op)) begin
            op_ld   = 1'b1;
            state_d = ST_KICK;
          end else begin
            retire  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_KICK: begin
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (exe_done) begin
          if (exe_err) begin
            stall_set = 1'b1;
          end else begin
            retire = 1'b1;
          end
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign stall_clr = ~unit_en & ~stall_set;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (retire) begin
      rd_q <= rd_wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
    end else if (stall_set) begin
      stall_q <= 1'b1;
    end else if (stall_clr) begin
      stall_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
    end else if (op_ld) begin
      op_q <= fetched_op;
    end
  end

  // Outputs
  assign mem_req    = (state_q == ST_FETCH);
  assign mem_addr   = cfg_base + {{OFS_PAD{1'b0}}, rd_q, {REC_SHIFT{1'b0}}};
  assign exe_start  = (state_q == ST_KICK);
  assign exe_opcode = op_q;
  assign rd_idx     = rd_q;
  assign stall      = stall_q;
  assign busy       = (state_q != ST_IDLE) | pending;

endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int unsigned IDX_W = 15,
  parameter int unsigned AW    = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unit_en,
  input  logic [AW-1:0]      cfg_base,
  input  logic [IDX_W:0]     cfg_depth,
  input  logic               wp_we,
  input  logic [31:0]        wp_wdata,
  output logic [31:0]        wp_rdata,
  output logic [31:0]        rp_rdata,
  output logic               busy,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_rvalid,
  input  logic [63:0]        mem_rdata,
  input  logic               mem_rerr,
  output logic               exe_start,
  output logic [7:0]         exe_opcode,
  output logic [AW-1:0]      exe_addr,
  input  logic               exe_done,
  input  logic               exe_err
);

  logic             rst_n_int;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_ok;
  logic [IDX_W-1:0] rd_idx;
  logic             stall;

  cmdq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cmdq_ptr_regs #(.IDX_W(IDX_W)) u_ptr_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wp_we     (wp_we),
    .wp_wdata  (wp_wdata),
    .cfg_depth (cfg_depth),
    .rd_idx    (rd_idx),
    .stall     (stall),
    .wr_idx    (wr_idx),
    .wr_ok     (wr_ok),
    .wp_rdata  (wp_rdata),
    .rp_rdata  (rp_rdata)
  );

  cmdq_seq #(.IDX_W(IDX_W), .AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .unit_en    (unit_en),
    .cfg_base   (cfg_base),
    .cfg_depth  (cfg_depth),
    .wr_idx     (wr_idx),
    .wr_ok      (wr_ok),
    .rd_idx     (rd_idx),
    .stall      (stall),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_rerr   (mem_rerr),
    .exe_start  (exe_start),
    .exe_opcode (exe_opcode),
    .exe_done   (exe_done),
    .exe_err    (exe_err)
  );

  assign exe_addr = mem_addr;

endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
  parameter int unsigned IDX_W = 15,
  parameter int unsigned AW    = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic           unit_en,
  input logic [AW-1:0]  cfg_base,
  input logic [IDX_W:0] cfg_depth,
  input logic [31:0]    rp_rdata,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_rvalid,
  input logic           mem_rerr,
  input logic           exe_start
);

  logic [AW-1:0] ofs;
  assign ofs = mem_addr - cfg_base;

  // R1: request targets a 32-byte slot inside the ring
  a_r1_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (ofs[4:0] == 5'd0) && ((ofs >> 5) < AW'(cfg_depth)));

  // R1: request and address held until answered
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R3: a fetch is only launched after a cycle with the unit enabled
  a_r3_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(unit_en));

  // R7: read error freezes the index and raises the stall flag
  a_r7_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && mem_rerr) |=> (rp_rdata[0] && $stable(rp_rdata[IDX_W+4:5])));

  // R9: no new fetch starts while stalled
  a_r9_no_fetch_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rp_rdata[0] |=> !$rose(mem_req));

  // R10: executor start is a single-cycle pulse
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |=> !exe_start);

  // R10: executor start never overlaps an outstanding read
  a_r10_start_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |-> !mem_req);

endmodule

bind cmdq_engine cmdq_engine_chk #(.IDX_W(IDX_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .unit_en    (unit_en),
  .cfg_base   (cfg_base),
  .cfg_depth  (cfg_depth),
  .rp_rdata   (rp_rdata),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .mem_rerr   (mem_rerr),
  .exe_start  (exe_start)
);

// File: tb/test_cmdq_engine.sv
module test_cmdq_engine;

  localparam int IDX_W = 15;
  localparam int AW    = 48;
  localparam logic [AW-1:0] BASE = 48'h0000_0001_2000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             unit_en;
  logic [AW-1:0]    cfg_base;
  logic [IDX_W:0]   cfg_depth;
  logic             wp_we;
  logic [31:0]      wp_wdata;
  logic [31:0]      wp_rdata;
  logic [31:0]      rp_rdata;
  logic             busy;
  logic             mem_req;
  logic [AW-1:0]    mem_addr;
  logic             mem_rvalid;
  logic [63:0]      mem_rdata;
  logic             mem_rerr;
  logic             exe_start;
  logic [7:0]       exe_opcode;
  logic [AW-1:0]    exe_addr;
  logic             exe_done;
  logic             exe_err;

  always #5 clk = ~clk;

  cmdq_engine #(.IDX_W(IDX_W), .AW(AW)) i_cmdq_engine (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cfg_base(cfg_base),
    .cfg_depth(cfg_depth), .wp_we(wp_we), .wp_wdata(wp_wdata),
    .wp_rdata(wp_rdata), .rp_rdata(rp_rdata), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .exe_start(exe_start),
    .exe_opcode(exe_opcode), .exe_addr(exe_addr), .exe_done(exe_done),
    .exe_err(exe_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Logs filled by the memory and executor models
  int            fetch_n = 0;
  logic [AW-1:0] fetch_log [0:255];
  int            exe_n = 0;
  logic [AW-1:0] exe_addr_log [0:255];
  logic [7:0]    exe_op_log [0:255];
  int            mem_err_idx = -1;
  int            exe_err_idx = -1;

  // Bench model of the ring
  int exp_rd, exp_wr, depth;
  bit exp_stall, exp_en;

  function automatic logic [7:0] op_of(input int idx);
    case (idx % 10)
      0: return 8'h03;
      1: return 8'h08;
      2: return 8'h04;
      3: return 8'h09;
      4: return 8'h05;
      5: return 8'h0A;
      6: return 8'h0B;
      7: return 8'h0F;
      8: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit is_map(input logic [7:0] op);
    return (op == 8'h08) || (op == 8'h09);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Memory read model: variable latency, opcode from record index
  initial begin
    int lat;
    int idx;
    lat = 1;
    mem_rvalid = 1'b0; mem_rerr = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rerr = 1'b0;
      if (mem_req) begin
        if (lat == 0) begin
          idx = int'((mem_addr - BASE) >> 5);
          if (fetch_n < 256) fetch_log[fetch_n] = mem_addr;
          fetch_n++;
          mem_rdata  = {56'h5AC3_9601_0203_09, op_of(idx)};
          mem_rerr   = (idx == mem_err_idx);
          mem_rvalid = 1'b1;
          lat = fetch_n % 3;
        end else begin
          lat--;
        end
      end
    end
  end

  // Executor model: completes three cycles after start
  initial begin
    int cnt;
    int cur;
    cnt = 0; cur = -1;
    exe_done = 1'b0; exe_err = 1'b0;
    forever begin
      @(negedge clk);
      exe_done = 1'b0; exe_err = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          exe_done = 1'b1;
          exe_err  = (cur == exe_err_idx);
        end
      end
      if (exe_start) begin
        if (exe_n < 256) begin
          exe_addr_log[exe_n] = exe_addr;
          exe_op_log[exe_n]   = exe_opcode;
        end
        exe_n++;
        cur = int'((exe_addr - BASE) >> 5);
        cnt = 3;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_rd = 0; exp_wr = 0; exp_stall = 1'b0;
  endtask

  // Walk the ring arithmetically, then compare against what the DUT did
  task automatic settle(input string tag);
    int idx, nf, ne, cyc;
    int fidx [0:63];
    int eidx [0:63];
    bit st, ok;
    idx = exp_rd; nf = 0; ne = 0; st = exp_stall;
    if (exp_en && !st && exp_wr < depth) begin
      while (idx != exp_wr) begin
        fidx[nf] = idx; nf++;
        if (idx == mem_err_idx) begin st = 1'b1; break; end
        if (is_map(op_of(idx))) begin
          eidx[ne] = idx; ne++;
          if (idx == exe_err_idx) begin st = 1'b1; break; end
        end
        idx = (idx + 1) % depth;
      end
    end
    chk(busy == (nf > 0), "R11", {tag, " busy at start"}, busy, nf > 0);
    cyc = 0;
    while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(cyc < 5000, "R11", {tag, " busy drops"}, cyc, 0);
    repeat (6) @(negedge clk);
    chk(fetch_n == nf, "R5", {tag, " records fetched"}, fetch_n, nf);
    ok = 1'b1;
    for (int k = 0; k < nf && k < fetch_n; k++)
      if (fetch_log[k] != BASE + AW'(fidx[k]) * 32) ok = 1'b0;
    chk(ok, "R1", {tag, " fetch addresses"}, ok, 1);
    chk(exe_n == ne, "R6", {tag, " executor starts"}, exe_n, ne);
    ok = 1'b1;
    for (int k = 0; k < ne && k < exe_n; k++)
      if (exe_addr_log[k] != BASE + AW'(eidx[k]) * 32 || exe_op_log[k] != op_of(eidx[k]))
        ok = 1'b0;
    chk(ok, "R6", {tag, " executor opcode/address"}, ok, 1);
    chk(rp_rdata == ((idx << 5) | int'(st)), "R7", {tag, " read pointer/stall"},
        rp_rdata, (idx << 5) | int'(st));
    exp_rd = idx; exp_stall = st;
    fetch_n = 0; exe_n = 0;
  endtask

  task automatic write_wp(input int target, input string tag);
    @(negedge clk);
    wp_we = 1'b1; wp_wdata = (target << 5) | 1;
    @(negedge clk);
    wp_we = 1'b0;
    exp_wr = target;
    chk(wp_rdata == 32'(target << 5), "R2", {tag, " write pointer readback"},
        wp_rdata, target << 5);
    settle(tag);
  endtask

  task automatic set_enable(input bit en, input string tag);
    @(negedge clk);
    unit_en = en;
    exp_en = en;
    @(negedge clk);
    @(negedge clk);
    if (!en) exp_stall = 1'b0;
    settle(tag);
  endtask

  // Watchdog
  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    unit_en = 1'b0; exp_en = 1'b0; cfg_base = BASE; cfg_depth = 16'd5; depth = 5;
    wp_we = 1'b0; wp_wdata = '0;
    do_reset();
    // R2: reset values
    chk(rp_rdata == 0, "R2", "reset read pointer", rp_rdata, 0);
    chk(wp_rdata == 0, "R2", "reset write pointer", wp_rdata, 0);
    chk(!busy && !mem_req && !exe_start, "R11", "reset idle outputs",
        {busy, mem_req, exe_start}, 0);

    // R3: nothing runs while disabled, starts on enable
    write_wp(3, "R3 disabled write");
    set_enable(1'b1, "R3 enable starts");

    // R5/R6: sweep depths and producer indices
    for (int d = 1; d <= 6; d++) begin
      cfg_depth = 16'(d); depth = d;
      do_reset();
      exp_en = 1'b1; unit_en = 1'b1;
      for (int s = 0; s <= d + 1; s++)
        write_wp((exp_rd * 3 + s + 1) % d, "R5 sweep");
      // R4: rejected indices
      write_wp(d, "R4 index equal to depth");
      write_wp(d + 2, "R4 index beyond depth");
      write_wp((exp_rd + d - 1) % d, "R5 long wrap");
    end

    // R7/R9: read error mid-run, stall persists, disable clears
    cfg_depth = 16'd8; depth = 8;
    do_reset();
    unit_en = 1'b1; exp_en = 1'b1;
    mem_err_idx = 2;
    write_wp(5, "R7 read error");
    write_wp(6, "R9 write while stalled");
    set_enable(1'b0, "R9 disable clears stall");
    mem_err_idx = -1;
    set_enable(1'b1, "R9 resume after enable");

    // R8: executor error across the wrap
    exe_err_idx = 3;
    write_wp(5, "R8 executor error");
    set_enable(1'b0, "R8 disable");
    exe_err_idx = -1;
    set_enable(1'b1, "R8 resume");
    write_wp(2, "R10 map commands after resume");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule